// File: doc/BRIEF.md
# DMX512 Packet Transmitter

This block sends DMX512 packets on one serial output line. A start request makes it emit a reset sequence, a null start code and then a chosen number of slot bytes. The slot bytes are fetched one at a time from an external byte memory through a single read port with one cycle of read latency. When the last stop bit of the final slot has left the line, the block raises a one-cycle completion pulse and goes back to idle. It then waits for the next request.

All characters go through one asynchronous transmit engine. The engine has a one-byte holding register in front of an 11-bit shifter, and each frame is one low start bit, eight data bits sent LSB first and two high stop bits. The break and the mark-after-break are not made by a timer of their own. They come from an ordinary 0x00 character sent at a slower bit rate: the start bit and eight zero bits give nine low bit times, and the two stop bits give the mark. A bit lasts (DIV+1)·OVS clocks. With a 32 MHz clock and OVS = 16, DIV_SLOW = 19 gives 100 kbaud and DIV_FAST = 7 gives 250 kbaud. The bit rate is changed only when both the holding register and the shifter are empty.

The sequencer has seven states:
- IDLE: no packet in progress.
- BREAK: loads the break character.
- BREAK_DRAIN: waits for the line to go fully empty, then selects the fast rate.
- START: loads the start code.
- FETCH: issues a memory read once the holding register is free.
- LOAD: writes the returned byte into the holding register.
- DRAIN: waits for the line to go fully empty before completing.

The transitions are:
- IDLE→BREAK on start.
- BREAK→BREAK_DRAIN unconditionally.
- BREAK_DRAIN→START when the line is idle.
- START→FETCH when slots remain, or START→DRAIN when the count is zero.
- FETCH→LOAD when the holding register is empty.
- LOAD→FETCH, or LOAD→DRAIN on the last slot.
- DRAIN→IDLE with the done pulse.

Top module: `dmx_packet_tx`

## Requirements
- R1: After reset, and whenever nothing is held or shifting, `tx_o` is high, `line_idle_o` is high, and `busy_o` and `done_o` are low.
- R2: A packet begins with a low break of exactly 9 slow bit times, (DIV_SLOW+1)·OVS clocks each. It is followed by a high mark of at least 2 slow bit times.
- R3: After the mark, a start code of 0x00 is sent at the fast rate, (DIV_FAST+1)·OVS clocks per bit, with a start bit of 0 and two stop bits of 1.
- R4: Slot bytes are read from addresses 0, 1, 2, … in order. Each read is `rd_en_o` high for one cycle, with the data on `rd_data_i` one cycle later. Each byte is sent at the fast rate as start 0, data LSB first, stop 1, stop 1.
- R5: Consecutive characters from the start code onward are gapless: each start bit begins in the clock right after the previous second stop bit ends.
- R6: The selected bit rate never changes while the holding register or the shifter holds data.
- R7: The slot count is captured when a start is accepted. A captured count of 0 sends only the break and the start code.
- R8: A start request while `busy_o` is high is ignored. The packet in flight keeps its count and content, and no new packet follows it.
- R9: `done_o` is high for exactly one cycle, one clock after the final stop bit ends. `busy_o` is high from the cycle after an accepted start until it falls in that same cycle.
- R10: `line_idle_o` is high exactly when the holding register and the shifter are both empty. `busy_o` low implies `line_idle_o` high.
- R11: A requested slot count above MAX_SLOTS is clamped to MAX_SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Packet start request, sampled while idle |
| slot_count_i | input | CNT_W | Number of slots to send |
| rd_en_o | output | 1 | Slot memory read strobe |
| rd_addr_o | output | ADDR_W | Slot memory read address |
| rd_data_i | input | 8 | Slot memory read data, valid one cycle after `rd_en_o` |
| tx_o | output | 1 | Serial line output, high when idle |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle packet completion pulse |
| line_idle_o | output | 1 | Holding register and shifter both empty |

## Verification
The assertions check the following on every cycle:
- The line stays high whenever the engine is empty.
- The bit rate is frozen whenever a character is held or shifting.
- The done pulse lasts one cycle and busy falls only with done.
- Reads happen only inside a packet.

Only the bench's scenarios can show the rest:
- The exact break and mark lengths.
- The decoded start code and slot bytes against memory.
- The gapless spacing between characters.
- The clamp and zero-count cases.
- That a start request in the middle of a packet changes neither its content nor what follows.

// File: rtl/dmx_tx_pkg.sv
`timescale 1ns/1ps
package dmx_tx_pkg;
    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 11;   // start + 8 data + 2 stop
    localparam int FRAME_CW   = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        SQ_IDLE        = 3'd0,
        SQ_BREAK       = 3'd1,
        SQ_BREAK_DRAIN = 3'd2,
        SQ_START       = 3'd3,
        SQ_FETCH       = 3'd4,
        SQ_LOAD        = 3'd5,
        SQ_DRAIN       = 3'd6
    } seq_state_t;
endpackage

// File: rtl/dmx_bit_timer.sv
`timescale 1ns/1ps
module dmx_bit_timer #(
    parameter int OVS      = 16,
    parameter int DIV_SLOW = 19,
    parameter int DIV_FAST = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic rate_fast_i,
    output logic bit_end_o
);
    localparam int SLOW_LEN = (DIV_SLOW + 1) * OVS;
    localparam int FAST_LEN = (DIV_FAST + 1) * OVS;
    localparam int MAX_LEN  = (SLOW_LEN > FAST_LEN) ? SLOW_LEN : FAST_LEN;
    localparam int CW       = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_LEN - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_LEN - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_c;

    always_comb begin
        last_c    = rate_fast_i ? FAST_LAST : SLOW_LAST;
        bit_end_o = run_i && (cnt_q == last_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || bit_end_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dmx_char_shifter.sv
`timescale 1ns/1ps
module dmx_char_shifter
    import dmx_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              bit_end_i,
    output logic              active_o,
    output logic              hold_full_o,
    output logic              line_o
);
    logic [BYTE_W-1:0]     hold_q;
    logic                  hold_full_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [FRAME_CW-1:0]   left_q;
    logic                  active_q;
    logic                  last_bit_c;
    logic                  load_c;

    always_comb begin
        last_bit_c = active_q && bit_end_i && (left_q == FRAME_CW'(1));
        load_c     = hold_full_q && (!active_q || last_bit_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            shreg_q     <= '1;
            left_q      <= '0;
            active_q    <= 1'b0;
        end else begin
            if (load_c) begin
                shreg_q     <= {2'b11, hold_q, 1'b0};
                left_q      <= FRAME_CW'(FRAME_BITS);
                active_q    <= 1'b1;
                hold_full_q <= 1'b0;
            end else if (active_q && bit_end_i) begin
                shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
                left_q  <= left_q - 1'b1;
                if (last_bit_c) begin
                    active_q <= 1'b0;
                end
            end
            if (wr_en_i) begin
                hold_q      <= wr_data_i;
                hold_full_q <= 1'b1;
            end
        end
    end

    assign active_o    = active_q;
    assign hold_full_o = hold_full_q;
    assign line_o      = active_q ? shreg_q[0] : 1'b1;
endmodule

// File: rtl/dmx_seq_fsm.sv
`timescale 1ns/1ps
module dmx_seq_fsm
    import dmx_tx_pkg::*;
#(
    parameter int MAX_SLOTS = 512,
    parameter int ADDR_W    = 9,
    parameter int CNT_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  slot_count_i,
    input  logic              line_idle_i,
    input  logic              hold_full_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              hold_wr_o,
    output logic [BYTE_W-1:0] hold_data_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rate_fast_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_SLOTS);

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  count_clamped_c;
    logic [ADDR_W-1:0] addr_q;
    logic              rate_q;
    logic              done_q;

    assign count_clamped_c = (slot_count_i > MAX_CNT) ? MAX_CNT : slot_count_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:        if (start_i) state_d = SQ_BREAK;
            SQ_BREAK:       state_d = SQ_BREAK_DRAIN;
            SQ_BREAK_DRAIN: if (line_idle_i) state_d = SQ_START;
            SQ_START:       state_d = (remain_q == '0) ? SQ_DRAIN : SQ_FETCH;
            SQ_FETCH:       if (!hold_full_i) state_d = SQ_LOAD;
            SQ_LOAD:        state_d = (remain_q == CNT_W'(1)) ? SQ_DRAIN : SQ_FETCH;
            SQ_DRAIN:       if (line_idle_i) state_d = SQ_IDLE;
            default:        state_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hold_wr_o   = 1'b0;
        hold_data_o = '0;
        rd_en_o     = 1'b0;
        unique case (state_q)
            SQ_BREAK, SQ_START: hold_wr_o = 1'b1;
            SQ_FETCH:           rd_en_o   = !hold_full_i;
            SQ_LOAD: begin
                hold_wr_o   = 1'b1;
                hold_data_o = rd_data_i;
            end
            default: ;
        endcase
        busy_o = (state_q != SQ_IDLE);
    end

    // packet datapath: captured count, address, rate and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            addr_q   <= '0;
            rate_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == SQ_DRAIN) && line_idle_i;
            if (state_q == SQ_IDLE && start_i) begin
                remain_q <= count_clamped_c;
                addr_q   <= '0;
                rate_q   <= 1'b0;
            end
            if (state_q == SQ_BREAK_DRAIN && line_idle_i) begin
                rate_q <= 1'b1;
            end
            if (state_q == SQ_LOAD) begin
                remain_q <= remain_q - 1'b1;
                addr_q   <= addr_q + 1'b1;
            end
        end
    end

    assign rd_addr_o   = addr_q;
    assign rate_fast_o = rate_q;
    assign done_o      = done_q;
endmodule

// File: rtl/dmx_packet_tx.sv
`timescale 1ns/1ps
module dmx_packet_tx
    import dmx_tx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int DIV_SLOW  = 19,
    parameter int DIV_FAST  = 7,
    parameter int MAX_SLOTS = 512,
    localparam int ADDR_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int CNT_W    = $clog2(MAX_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  slot_count_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              tx_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              line_idle_o
);
    logic              hold_wr;
    logic [BYTE_W-1:0] hold_data;
    logic              hold_full;
    logic              eng_active;
    logic              bit_end;
    logic              rate_fast;

    assign line_idle_o = !eng_active && !hold_full;

    dmx_seq_fsm #(
        .MAX_SLOTS (MAX_SLOTS),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .slot_count_i (slot_count_i),
        .line_idle_i  (line_idle_o),
        .hold_full_i  (hold_full),
        .rd_data_i    (rd_data_i),
        .hold_wr_o    (hold_wr),
        .hold_data_o  (hold_data),
        .rd_en_o      (rd_en_o),
        .rd_addr_o    (rd_addr_o),
        .rate_fast_o  (rate_fast),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    dmx_bit_timer #(
        .OVS      (OVS),
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (eng_active),
        .rate_fast_i (rate_fast),
        .bit_end_o   (bit_end)
    );

    dmx_char_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (hold_wr),
        .wr_data_i   (hold_data),
        .bit_end_i   (bit_end),
        .active_o    (eng_active),
        .hold_full_o (hold_full),
        .line_o      (tx_o)
    );
endmodule

// File: rtl/dmx_packet_tx_chk.sv
`timescale 1ns/1ps
module dmx_packet_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_o,
    input logic busy_o,
    input logic done_o,
    input logic line_idle_o,
    input logic rd_en_o,
    input logic rate_fast,
    input logic eng_active
);
    // R1: an empty engine leaves the line at mark
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        line_idle_o |-> tx_o);

    // R6: bit rate frozen while anything is held or shifting
    a_r6_rate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !line_idle_o |-> $stable(rate_fast));

    // R9: completion pulse is a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: busy only drops together with done
    a_r9_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R10: not busy implies nothing left in the engine
    a_r10_idle_when_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (line_idle_o && !eng_active));

    // R4: slot reads are single-cycle strobes inside a packet
    a_r4_read_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> busy_o);

    a_r4_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o);
endmodule

bind dmx_packet_tx dmx_packet_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_o        (tx_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .line_idle_o (line_idle_o),
    .rd_en_o     (rd_en_o),
    .rate_fast   (rate_fast),
    .eng_active  (eng_active)
);

// File: tb/tb_dmx_packet_tx.sv
`timescale 1ns/1ps
module tb_dmx_packet_tx;
    localparam int OVS       = 4;
    localparam int DIV_SLOW  = 4;
    localparam int DIV_FAST  = 1;
    localparam int MAX_SLOTS = 6;
    localparam int ADDR_W    = $clog2(MAX_SLOTS);
    localparam int CNT_W     = $clog2(MAX_SLOTS + 1);
    localparam int SB        = (DIV_SLOW + 1) * OVS;
    localparam int FB        = (DIV_FAST + 1) * OVS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  slot_count_i = '0;
    logic              rd_en_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic [7:0]        rd_data_i = '0;
    logic              tx_o, busy_o, done_o, line_idle_o;

    logic [7:0] mem [0:MAX_SLOTS-1];

    int checks = 0;
    int errors = 0;
    int early_done = 0;
    bit poke_now = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

    dmx_packet_tx #(
        .OVS(OVS), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .MAX_SLOTS(MAX_SLOTS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .slot_count_i(slot_count_i),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o), .line_idle_o(line_idle_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Receives one fast-rate character starting at its first low cycle.
    task automatic rx_char(output logic [7:0] data, output bit framed);
        logic [10:0] fr;
        fr = '1;
        for (int i = 0; i < 11 * FB; i++) begin
            if (i % FB == FB / 2) fr[i / FB] = tx_o;
            if (done_o) early_done++;
            if (poke_now && i == 3 * FB) begin
                start_i      = 1'b1;
                slot_count_i = '0;
            end
            if (poke_now && i == 3 * FB + 1) start_i = 1'b0;
            step();
        end
        data   = fr[8:1];
        framed = (fr[0] == 1'b0) && (fr[10:9] == 2'b11);
    endtask

    task automatic run_packet(input int req_cnt, input logic [7:0] seed, input bit poke);
        int n, lows, highs, waitc;
        logic [7:0] d;
        bit fr_ok;
        n = (req_cnt > MAX_SLOTS) ? MAX_SLOTS : req_cnt;
        for (int i = 0; i < MAX_SLOTS; i++) mem[i] = seed ^ 8'(i * 29 + 3);
        early_done = 0;
        slot_count_i = CNT_W'(req_cnt);
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
        waitc = 0;
        while (tx_o == 1'b1 && waitc < 20) begin waitc++; step(); end
        lows = 0;
        while (tx_o == 1'b0 && lows < 10 * SB) begin lows++; step(); end
        chk(lows == 9 * SB, "R2 break length", lows, 9 * SB);
        highs = 0;
        while (tx_o == 1'b1 && highs < 4 * SB) begin highs++; step(); end
        chk(highs >= 2 * SB && highs < 3 * SB, "R2 mark length", highs, 2 * SB);
        poke_now = poke;
        rx_char(d, fr_ok);
        poke_now = 1'b0;
        chk(fr_ok && d == 8'h00, "R3 start code", int'(d), 0);
        for (int s = 0; s < n; s++) begin
            chk(tx_o == 1'b0, "R5 gapless next char", int'(tx_o), 0);
            rx_char(d, fr_ok);
            chk(fr_ok && d == mem[s], "R4 slot data", int'(d), int'(mem[s]));
        end
        // now one clock after... at the cycle where the last stop bit has ended
        chk(done_o == 1'b0 && tx_o == 1'b1, "R9 no done before end", int'(done_o), 0);
        step();
        chk(done_o == 1'b1 && busy_o == 1'b0 && line_idle_o == 1'b1,
            "R9 done after last stop bit", int'(done_o), 1);
        step();
        chk(done_o == 1'b0, "R9 done single cycle", int'(done_o), 0);
        chk(early_done == 0, "R8 R7 no early done", early_done, 0);
        for (int k = 0; k < 3 * SB; k++) begin
            if (tx_o != 1'b1 || busy_o != 1'b0) begin
                chk(1'b0, "R8 R10 stays idle after packet", int'(tx_o), 1);
                break;
            end
            step();
        end
        chk(line_idle_o == 1'b1 && tx_o == 1'b1, "R1 R10 idle between packets",
            int'(line_idle_o), 1);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        chk(tx_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0 && line_idle_o == 1'b1,
            "R1 reset state", int'(tx_o), 1);
        rst_n = 1'b1;
        repeat (2) step();
        chk(tx_o == 1'b1 && line_idle_o == 1'b1, "R1 idle after reset", int'(tx_o), 1);
        // R7 zero count, R4 counts 1..MAX, R11 clamp above MAX
        for (int c = 0; c <= MAX_SLOTS + 1; c++) begin
            run_packet(c, 8'(8'hA5 + c * 17), 1'b0);
        end
        run_packet(MAX_SLOTS, 8'hFF, 1'b0);
        run_packet(MAX_SLOTS, 8'h00, 1'b0);
        // R8 start request and count change in flight are ignored (R7 count latched)
        run_packet(4, 8'h3C, 1'b1);
        run_packet(0, 8'h11, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule